// File: doc/BRIEF.md
# Floppy Controller Host-Interface Phase Sequencer

This block implements the byte-wide host side of a floppy disk controller. The host writes an opcode byte and then a decoded number of parameter bytes into the data register. The block then runs the command, and where the command produces status it offers a fixed number of result bytes for the host to read back. A main status byte reports whether the data register is ready for the host, which way data moves, whether payload is moving without DMA, and whether a command is in progress.

Drive mechanics and the DMA engine sit outside the block. A stub on the media port sees the parameter and payload buffer. It receives a start pulse for DMA transfers and answers with a done strobe and a status byte. In non-DMA mode the payload moves through the same buffer, addressed by the running byte position modulo its depth.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset the block is in the command phase. The status byte is 0x80 and the interrupt is low. Status bits: bit 7 request-for-master, bit 6 direction-out (host reads), bit 5 non-DMA, bit 4 command-busy, bits 3..0 zero.
- R2: The first byte written in the command phase is the opcode and sets command-busy. Request-for-master stays set only if the opcode has parameters, which gives status 0x90 with parameters and 0x10 without.
- R3: Opcode decode by first match:
  - (op & 0x1F)==0x06 is a read transfer with 8 parameters.
  - (op & 0x3F)==0x05 is a write transfer with 8 parameters.
  - 0x0F and 0x03 take 2 parameters and return nothing.
  - 0x10, 0x18, 0x0E and 0x2E take no parameters.
  - Every other opcode is invalid and takes no parameters.
- R4: When the byte count reaches the opcode plus its parameters, request-for-master clears and the execution phase is held for one cycle (status 0x10). Commands that return nothing then go back to the command phase (status 0x80).
- R5: The result phase has status 0xD0. Result byte counts are 7 for a transfer, 1 for 0x10, 1 for 0x18, 1 for an invalid opcode, 10 for 0x0E and 15 for 0x2E. Byte 0 is the code and the rest are 0x00. The codes are VERSION_ID (default 0x90) for 0x10, 0x41 for 0x18, 0x80 for an invalid opcode, and 0x00 for 0x0E and 0x2E.
- R6: Reading the last result byte returns the block to the command phase with status 0x80 and drops the interrupt.
- R7: With non-DMA mode selected at execution start, the transfer length is sampled from the length input (at least 1). The status is 0xB0 for a write and 0xF0 for a read. Payload byte k is stored to, or read from, buffer address k mod FIFO_DEPTH.
- R8: After the sampled number of non-DMA bytes, the status becomes 0xD0, the interrupt rises, and a 7-byte result with code 0x00 follows.
- R9: A transfer in DMA mode pulses the start output in the first execution cycle and holds status 0x10 until the done strobe. On the done strobe it enters a 7-byte result whose code is the stub's status byte, with the interrupt raised.
- R10: A data-register read in the command phase, or a write in the result phase, changes neither the phase, the position nor the status.
- R11: The opcode is stored at buffer address 0 and parameter i at address i, where the media port can read them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host data-register write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host data-register read strobe |
| rd_data_o | output | 8 | Host read byte |
| msr_o | output | 8 | Main status byte |
| irq_o | output | 1 | Interrupt |
| nondma_i | input | 1 | Non-DMA mode select, sampled at execution start |
| xfer_len_i | input | LEN_W | Non-DMA transfer length in bytes |
| exec_start_o | output | 1 | DMA transfer start pulse to stub |
| exec_done_i | input | 1 | Stub completion strobe |
| exec_status_i | input | 8 | Stub status byte for the result |
| media_addr_i | input | AW | Stub buffer address |
| media_we_i | input | 1 | Stub buffer write enable |
| media_wdata_i | input | 8 | Stub buffer write byte |
| media_rdata_o | output | 8 | Stub buffer read byte |

## Verification
The hardest state to reach is the wrap of the payload position past the buffer depth in the middle of a non-DMA transfer. Only there do stored and returned bytes depend on the modulo addressing, so the stimulus runs 600-byte transfers in both directions and then inspects the whole buffer through the media port. Every one of the 256 opcodes is swept, with DMA completion for the transfer opcodes. Ignored accesses are placed in the middle of parameter collection and in the middle of a long result, so that a shifted position would show up as a wrong byte count.

// File: rtl/fdc_phase_pkg.sv
package fdc_phase_pkg;
  typedef enum logic [1:0] {PH_CMD = 2'd1, PH_EXEC = 2'd2, PH_RES = 2'd3} phase_e;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_VERSION, K_PARTID, K_DUMP, K_SAVE, K_INVALID
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [3:0] n_params;
  } cmd_info_t;

  localparam int MSR_RQM  = 7;
  localparam int MSR_DIO  = 6;
  localparam int MSR_NDMA = 5;
  localparam int MSR_BUSY = 4;

  function automatic logic [3:0] kind_res_len(kind_e k);
    case (k)
      K_READ, K_WRITE:               return 4'd7;
      K_VERSION, K_PARTID, K_INVALID: return 4'd1;
      K_DUMP:                        return 4'd10;
      K_SAVE:                        return 4'd15;
      default:                       return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_phase_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_info_t  info_o
);
  localparam int N_CMD = 8;
  localparam logic [7:0] OP_VAL [N_CMD] = '{8'h06, 8'h05, 8'h0F, 8'h03, 8'h10, 8'h18, 8'h0E, 8'h2E};
  localparam logic [7:0] OP_MSK [N_CMD] = '{8'h1F, 8'h3F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam kind_e      OP_KND [N_CMD] = '{K_READ, K_WRITE, K_NONE, K_NONE,
                                            K_VERSION, K_PARTID, K_DUMP, K_SAVE};
  localparam logic [3:0] OP_PRM [N_CMD] = '{4'd8, 4'd8, 4'd2, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0};

  // first match wins; table order is the priority
  always_comb begin
    logic hit;
    hit    = 1'b0;
    info_o = '{kind: K_INVALID, n_params: 4'd0};
    for (int i = 0; i < N_CMD; i++) begin
      if (!hit && ((op_i & OP_MSK[i]) == OP_VAL[i])) begin
        hit    = 1'b1;
        info_o = '{kind: OP_KND[i], n_params: OP_PRM[i]};
      end
    end
  end
endmodule

// File: rtl/fdc_byte_fifo.sv
module fdc_byte_fifo #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [7:0]    h_wdata_i,
  output logic [7:0]    h_rdata_o,
  input  logic          s_we_i,
  input  logic [AW-1:0] s_addr_i,
  input  logic [7:0]    s_wdata_i,
  output logic [7:0]    s_rdata_o
);
  logic [7:0] mem [DEPTH];

  // host port wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (h_we_i) mem[h_addr_i] <= h_wdata_i;
    if (s_we_i && !(h_we_i && (h_addr_i == s_addr_i))) mem[s_addr_i] <= s_wdata_i;
  end

  assign h_rdata_o = mem[h_addr_i];
  assign s_rdata_o = mem[s_addr_i];
endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_phase_pkg::*;
#(
  parameter int           FIFO_DEPTH = 512,
  parameter int           LEN_W      = 16,
  parameter logic [7:0]   VERSION_ID = 8'h90,
  localparam int          AW         = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       msr_o,
  output logic             irq_o,
  input  logic             nondma_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  output logic             exec_start_o,
  input  logic             exec_done_i,
  input  logic [7:0]       exec_status_i,
  input  logic [AW-1:0]    media_addr_i,
  input  logic             media_we_i,
  input  logic [7:0]       media_wdata_i,
  output logic [7:0]       media_rdata_o
);
  phase_e           phase_q;
  kind_e            kind_q;
  logic [LEN_W-1:0] pos_q, len_q, pos_inc, len_eff;
  logic             rqm_q, dio_q, ndma_q, busy_q, irq_q, launch_q;
  logic [7:0]       code_q, fifo_rdata;
  logic             host_wr, host_rd, is_xfer;
  cmd_info_t        dec_info;

  fdc_cmd_decode u_dec (.op_i(wr_data_i), .info_o(dec_info));

  fdc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .h_we_i   (host_wr),
    .h_addr_i (pos_q[AW-1:0]),
    .h_wdata_i(wr_data_i),
    .h_rdata_o(fifo_rdata),
    .s_we_i   (media_we_i),
    .s_addr_i (media_addr_i),
    .s_wdata_i(media_wdata_i),
    .s_rdata_o(media_rdata_o)
  );

  // direction bit gates the access: reads in command phase and writes in result phase fall out here
  assign host_wr = wr_en_i && rqm_q && !dio_q;
  assign host_rd = rd_en_i && rqm_q && dio_q;
  assign pos_inc = pos_q + LEN_W'(1);
  assign len_eff = (pos_q == '0) ? LEN_W'(dec_info.n_params) + LEN_W'(1) : len_q;
  assign is_xfer = (kind_q == K_READ) || (kind_q == K_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      kind_q   <= K_NONE;
      pos_q    <= '0;
      len_q    <= LEN_W'(1);
      rqm_q    <= 1'b1;
      dio_q    <= 1'b0;
      ndma_q   <= 1'b0;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
      launch_q <= 1'b0;
      code_q   <= '0;
    end else begin
      launch_q <= 1'b0;
      case (phase_q)
        PH_CMD: if (host_wr) begin
          pos_q <= pos_inc;
          if (pos_q == '0) begin
            kind_q <= dec_info.kind;
            len_q  <= len_eff;
            busy_q <= 1'b1;
          end
          if (pos_inc == len_eff) begin
            rqm_q    <= 1'b0;
            phase_q  <= PH_EXEC;
            launch_q <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (launch_q) begin
            case (kind_q)
              K_NONE: begin
                phase_q <= PH_CMD;
                pos_q   <= '0;
                len_q   <= LEN_W'(1);
                rqm_q   <= 1'b1;
                dio_q   <= 1'b0;
                busy_q  <= 1'b0;
              end
              K_READ, K_WRITE: if (nondma_i) begin
                ndma_q <= 1'b1;
                rqm_q  <= 1'b1;
                dio_q  <= (kind_q == K_READ);
                pos_q  <= '0;
                len_q  <= xfer_len_i;
              end
              default: begin
                phase_q <= PH_RES;
                pos_q   <= '0;
                len_q   <= LEN_W'(kind_res_len(kind_q));
                rqm_q   <= 1'b1;
                dio_q   <= 1'b1;
                code_q  <= (kind_q == K_VERSION) ? VERSION_ID :
                           (kind_q == K_PARTID)  ? 8'h41 :
                           (kind_q == K_INVALID) ? 8'h80 : 8'h00;
              end
            endcase
          end else if (ndma_q) begin
            if (host_wr || host_rd) begin
              pos_q <= pos_inc;
              if (pos_inc == len_q) begin
                phase_q <= PH_RES;
                ndma_q  <= 1'b0;
                rqm_q   <= 1'b1;
                dio_q   <= 1'b1;
                pos_q   <= '0;
                len_q   <= LEN_W'(7);
                code_q  <= 8'h00;
                irq_q   <= 1'b1;
              end
            end
          end else if (exec_done_i && is_xfer) begin
            phase_q <= PH_RES;
            rqm_q   <= 1'b1;
            dio_q   <= 1'b1;
            pos_q   <= '0;
            len_q   <= LEN_W'(7);
            code_q  <= exec_status_i;
            irq_q   <= 1'b1;
          end
        end
        PH_RES: if (host_rd) begin
          pos_q <= pos_inc;
          if (pos_inc == len_q) begin
            phase_q <= PH_CMD;
            pos_q   <= '0;
            len_q   <= LEN_W'(1);
            rqm_q   <= 1'b1;
            dio_q   <= 1'b0;
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
          end
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  assign rd_data_o    = (phase_q == PH_RES) ? ((pos_q == '0) ? code_q : 8'h00) : fifo_rdata;
  assign msr_o        = {rqm_q, dio_q, ndma_q, busy_q, 4'b0000};
  assign irq_o        = irq_q;
  assign exec_start_o = launch_q && is_xfer && !nondma_i;

  AST_CMD_HOST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD) |-> (!dio_q && !ndma_q)) else $error("cmd dir");                 // R2
  AST_PARAMS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && host_wr && pos_inc == len_eff) |=> (phase_q == PH_EXEC && !rqm_q)) else $error("params"); // R4
  AST_RES_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RES) |-> (rqm_q && dio_q && !ndma_q && busy_q)) else $error("res flags"); // R5
  AST_LAST_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RES && host_rd && pos_inc == len_q) |=> (phase_q == PH_CMD && !irq_q && rqm_q)) else $error("last"); // R6
  AST_NDMA_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && !launch_q && ndma_q && (host_wr || host_rd) && pos_inc == len_q)
    |=> (phase_q == PH_RES && irq_q && !ndma_q)) else $error("ndma done");              // R8
  AST_DMA_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && !ndma_q) |-> !rqm_q) else $error("dma rqm");                  // R9
  AST_RD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && rd_en_i && !wr_en_i) |=> ($stable(pos_q) && phase_q == PH_CMD)) else $error("rd ign"); // R10
endmodule

// File: tb/fdc_phase_seq_test.sv
module fdc_phase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int AW         = 9;
  localparam int XLEN       = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data, msr;
  logic        irq, nondma = 1'b0, exec_start, exec_done = 1'b0;
  logic [15:0] xfer_len = 16'(XLEN);
  logic [7:0]  exec_status = '0;
  logic [AW-1:0] m_addr = '0;
  logic        m_we = 1'b0;
  logic [7:0]  m_wdata = '0, m_rdata;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_phase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .msr_o(msr), .irq_o(irq),
    .nondma_i(nondma), .xfer_len_i(xfer_len), .exec_start_o(exec_start),
    .exec_done_i(exec_done), .exec_status_i(exec_status),
    .media_addr_i(m_addr), .media_we_i(m_we), .media_wdata_i(m_wdata),
    .media_rdata_o(m_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hrd(output logic [7:0] v);
    rd_en = 1'b1; #1; v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int exp_params(input logic [7:0] op);
    if ((op & 8'h1F) == 8'h06 || (op & 8'h3F) == 8'h05) return 8;
    if (op == 8'h0F || op == 8'h03) return 2;
    return 0;
  endfunction

  function automatic bit is_xfer(input logic [7:0] op);
    return ((op & 8'h1F) == 8'h06) || ((op & 8'h3F) == 8'h05);
  endfunction

  function automatic int exp_rlen(input logic [7:0] op);
    if (is_xfer(op)) return 7;
    if (op == 8'h0F || op == 8'h03) return 0;
    if (op == 8'h0E) return 10;
    if (op == 8'h2E) return 15;
    return 1;
  endfunction

  function automatic logic [7:0] exp_code(input logic [7:0] op);
    if (is_xfer(op)) return ~op;
    if (op == 8'h10) return 8'h90;
    if (op == 8'h18) return 8'h41;
    if (op == 8'h0E || op == 8'h2E) return 8'h00;
    return 8'h80;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 msr", msr, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // exhaustive opcode sweep, DMA mode
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      int np, rl;
      o = 8'(op); np = exp_params(o); rl = exp_rlen(o);
      hwr(o);
      chk("R2 msr after opcode", msr, (np > 0) ? 8'h90 : 8'h10);
      for (int i = 1; i <= np; i++) begin
        chk("R3 rqm while collecting", msr, 8'h90);
        hwr(o ^ 8'(i));
      end
      chk("R4 exec entry", msr, 8'h10);
      chk("R9 start pulse", {7'b0, exec_start}, {7'b0, is_xfer(o)});
      @(negedge clk);
      if (is_xfer(o)) begin
        chk("R9 dma wait", msr, 8'h10);
        chk("R9 pulse end", {7'b0, exec_start}, 8'h00);
        exec_done = 1'b1; exec_status = ~o;
        @(negedge clk);
        exec_done = 1'b0;
        chk("R9 irq", {7'b0, irq}, 8'h01);
      end
      if (rl == 0) chk("R4 no-result return", msr, 8'h80);
      else begin
        chk("R5 result msr", msr, 8'hD0);
        for (int k = 0; k < rl; k++) begin
          hrd(v);
          chk("R5 result byte", v, (k == 0) ? exp_code(o) : 8'h00);
        end
      end
      chk("R6 back to command", msr, 8'h80);
      chk("R6 irq low", {7'b0, irq}, 8'h00);
    end

    // ignored accesses
    hrd(v);
    chk("R10 read in command", msr, 8'h80);
    hwr(8'h0F);
    hrd(v);
    chk("R10 read mid params", msr, 8'h90);
    hwr(8'h01); hwr(8'h02);
    @(negedge clk);
    chk("R10 param count intact", msr, 8'h80);
    hwr(8'h0E);
    @(negedge clk);
    for (int k = 0; k < 3; k++) hrd(v);
    hwr(8'h33);
    chk("R10 write in result", msr, 8'hD0);
    for (int k = 3; k < 10; k++) begin
      hrd(v);
      chk("R10 remaining byte", v, 8'h00);
    end
    chk("R10 count intact", msr, 8'h80);

    // non-DMA write with wrap
    nondma = 1'b1;
    hwr(8'h45);
    for (int i = 1; i <= 8; i++) hwr(8'hA0 + 8'(i));
    for (int a = 0; a <= 8; a++) begin
      m_addr = AW'(a); #1;
      chk("R11 param store", m_rdata, (a == 0) ? 8'h45 : 8'hA0 + 8'(a));
    end
    @(negedge clk);
    chk("R7 ndma write msr", msr, 8'hB0);
    for (int k = 0; k < XLEN; k++) begin
      if (k == XLEN - 1) chk("R8 before last", msr, 8'hB0);
      hwr(8'(k * 7 + 3));
    end
    chk("R8 done msr", msr, 8'hD0);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    for (int a = 0; a < DEPTH; a++) begin
      int k;
      k = (a < XLEN - DEPTH) ? a + DEPTH : a;
      m_addr = AW'(a); #1;
      chk("R7 payload addr", m_rdata, 8'(k * 7 + 3));
    end
    for (int k = 0; k < 7; k++) begin
      hrd(v);
      chk("R8 result byte", v, 8'h00);
    end
    chk("R6 after ndma", msr, 8'h80);

    // non-DMA read with wrap
    hwr(8'hE6);
    for (int i = 1; i <= 8; i++) hwr(8'(i));
    m_we = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      m_addr = AW'(a); m_wdata = 8'(a) ^ 8'h5A;
      @(negedge clk);
    end
    m_we = 1'b0;
    chk("R7 ndma read msr", msr, 8'hF0);
    for (int k = 0; k < XLEN; k++) begin
      hrd(v);
      chk("R7 read payload", v, 8'(k % DEPTH) ^ 8'h5A);
    end
    chk("R8 read done msr", msr, 8'hD0);
    chk("R8 read irq", {7'b0, irq}, 8'h01);
    for (int k = 0; k < 7; k++) hrd(v);
    chk("R6 final", msr, 8'h80);
    chk("R6 final irq", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule